// File: doc/BRIEF.md
# Sample Buffer with Command Strobes and Half-Full Interrupt

This block sits between a 12-bit converter and a host on a 16-bit word bus addressed by byte offset. Finished samples from the converter go into a 1K-word first-in first-out buffer while conversion is allowed. The host drains them through a data port, where each read removes one sample. A packed status word shows the buffer fill state with active-low flags. It also shows a conversion-ready flag, a sticky overrun flag, the conversion enable, the analog output enable and the interrupt state.

Side effects come from writing to dedicated offsets, and the written value does not matter. One offset empties the buffer and one clears the latched flags. Others allow conversion, block conversion, enable both analog outputs, or request a single software conversion. When the buffer fill rises to half its depth, an interrupt request is latched so that the host can start a batch transfer. The request stays high until the flags are cleared.

Top module: `acq_fifo_regs`

## Requirements
- R1: After reset the status word at offset 0x02 reads 0x0086. The interrupt request, the conversion enable, the analog output enable and the software conversion pulse are all low.
- R2: Accepted samples are returned in arrival order by reads at offset 0x06. The sample sits in bits 11:0 and bits 15:12 read zero. Each read at 0x06 with data present removes exactly one sample.
- R3: Status bit 0 is 0 exactly when the buffer holds no samples. Bit 1 is 0 exactly when it holds at least DEPTH/2 samples. Bit 2 is 0 exactly when it holds DEPTH samples.
- R4: Status bit 3 (ready) becomes 1 at the clock edge where a sample arrives while conversion is allowed. A write to offset 0x16 while conversion is allowed clears it, and so does a write to offset 0x12.
- R5: A write to offset 0x16 while conversion is allowed drives `sw_conv_o` high for exactly one cycle. While conversion is blocked, the write produces no pulse.
- R6: A write to offset 0x18 allows conversion and a write to offset 0x1A blocks it. Status bit 6 and `conv_en_o` show the current setting. Samples that arrive while conversion is blocked are ignored and leave the status word unchanged.
- R7: A write to offset 0x10 empties the buffer. The next accepted sample is the next one read back.
- R8: A write to offset 0x12 clears the ready, overrun and interrupt flags.
- R9: A write to offset 0x14 enables both analog outputs. `dac_en_o` goes high and status bit 7 reads 0 from then on.
- R10: `irq_o` and status bit 14 rise at the clock edge where the fill count goes from below DEPTH/2 to DEPTH/2 or more. They stay high until a write to 0x12, even when the buffer is emptied or drained.
- R11: A sample that arrives while the buffer is full, with no read in the same cycle, is dropped. It sets the sticky overrun flag in status bit 5.
- R12: A read at offset 0x06 while the buffer is empty changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_addr_i | input | 5 | Byte offset of the access |
| bus_rdata_o | output | 16 | Read data for the addressed offset |
| smp_valid_i | input | 1 | Converter has finished a sample |
| smp_data_i | input | 12 | Converted sample value |
| sw_conv_o | output | 1 | Single-cycle software conversion request |
| conv_en_o | output | 1 | Conversion allowed |
| dac_en_o | output | 1 | Analog outputs enabled |
| irq_o | output | 1 | Held interrupt request |

## Verification
The buffer is filled one sample at a time from empty to full. The status word is compared after every step, which separates the boundaries at one sample, DEPTH/2 and DEPTH. The drain runs over the whole depth with a distinct value per slot, so any ordering or pointer-wrap fault shows up as a mismatch. Reads while empty, samples while full, a clear while the interrupt is pending, and samples while conversion is blocked are each followed by a status read or a read-back. This shows that the flag or the buffer contents were left alone or changed as required.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int unsigned ADDR_W = 5;

    // Byte offsets on the host bus
    localparam logic [ADDR_W-1:0] OFF_STATUS   = 5'h02;
    localparam logic [ADDR_W-1:0] OFF_DATA     = 5'h06;
    localparam logic [ADDR_W-1:0] OFF_CLR_FIFO = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_CLR_FLAG = 5'h12;
    localparam logic [ADDR_W-1:0] OFF_DAC_ON   = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_POLL     = 5'h16;
    localparam logic [ADDR_W-1:0] OFF_CONV_ON  = 5'h18;
    localparam logic [ADDR_W-1:0] OFF_CONV_OFF = 5'h1A;

    // Status word bit positions
    localparam int unsigned ST_NEMPTY = 0;
    localparam int unsigned ST_NHALF  = 1;
    localparam int unsigned ST_NFULL  = 2;
    localparam int unsigned ST_READY  = 3;
    localparam int unsigned ST_OVR    = 5;
    localparam int unsigned ST_CONV   = 6;
    localparam int unsigned ST_NDAC   = 7;
    localparam int unsigned ST_IRQ    = 14;

    typedef struct packed {
        logic clr_fifo;
        logic clr_flag;
        logic dac_on;
        logic poll;
        logic conv_on;
        logic conv_off;
        logic pop_req;
    } cmd_t;

endpackage

// File: rtl/acq_cmd_decode.sv
module acq_cmd_decode
    import acq_pkg::*;
(
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output cmd_t              cmd_o
);

    always_comb begin
        cmd_o = '0;
        if (wr_en_i) begin
            case (addr_i)
                OFF_CLR_FIFO: cmd_o.clr_fifo = 1'b1;
                OFF_CLR_FLAG: cmd_o.clr_flag = 1'b1;
                OFF_DAC_ON:   cmd_o.dac_on   = 1'b1;
                OFF_POLL:     cmd_o.poll     = 1'b1;
                OFF_CONV_ON:  cmd_o.conv_on  = 1'b1;
                OFF_CONV_OFF: cmd_o.conv_off = 1'b1;
                default:      ;
            endcase
        end
        cmd_o.pop_req = rd_en_i && (addr_i == OFF_DATA);
    end

endmodule

// File: rtl/acq_fifo.sv
module acq_fifo #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              empty_o,
    output logic              half_o,
    output logic              full_o,
    output logic              half_hit_o,
    output logic              drop_o
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.cnt != '0) && !clr_i;
        do_push = push_i && !clr_i && ((st_q.cnt != FULL_C) || do_pop);
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = st_q.wp + AW'(1);
            if (do_pop)  st_d.rp = st_q.rp + AW'(1);
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata_i;
    end

    assign rdata_o    = mem[st_q.rp];
    assign empty_o    = (st_q.cnt == '0);
    assign half_o     = (st_q.cnt >= HALF_C);
    assign full_o     = (st_q.cnt == FULL_C);
    assign half_hit_o = (st_d.cnt >= HALF_C) && (st_q.cnt < HALF_C);
    assign drop_o     = push_i && !clr_i && !do_push;

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_C);

    // R12
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i && !clr_i) |=> (empty_o && $stable(st_q.rp)));

    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o);

endmodule

// File: rtl/acq_flags.sv
module acq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_flag_i,
    input  logic dac_on_i,
    input  logic poll_i,
    input  logic conv_on_i,
    input  logic conv_off_i,
    input  logic smp_valid_i,
    input  logic half_hit_i,
    input  logic drop_i,
    output logic take_o,
    output logic sw_conv_o,
    output logic conv_en_o,
    output logic dac_en_o,
    output logic ready_o,
    output logic ovr_o,
    output logic irq_o
);

    typedef struct packed {
        logic conv_en;
        logic dac_en;
        logic ready;
        logic ovr;
        logic irq;
    } flag_st_t;

    flag_st_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (conv_on_i)  fl_d.conv_en = 1'b1;
        if (conv_off_i) fl_d.conv_en = 1'b0;
        if (dac_on_i)   fl_d.dac_en  = 1'b1;
        if (clr_flag_i) begin
            fl_d.ready = 1'b0;
            fl_d.ovr   = 1'b0;
            fl_d.irq   = 1'b0;
        end
        if (poll_i && fl_q.conv_en)      fl_d.ready = 1'b0;
        if (smp_valid_i && fl_q.conv_en) fl_d.ready = 1'b1;
        if (drop_i)                      fl_d.ovr   = 1'b1;
        if (half_hit_i)                  fl_d.irq   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign take_o    = smp_valid_i && fl_q.conv_en;
    assign sw_conv_o = poll_i && fl_q.conv_en;
    assign conv_en_o = fl_q.conv_en;
    assign dac_en_o  = fl_q.dac_en;
    assign ready_o   = fl_q.ready;
    assign ovr_o     = fl_q.ovr;
    assign irq_o     = fl_q.irq;

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_flag_i) |=> irq_o);

    // R9
    dac_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_on_i |=> dac_en_o);

    // R6
    conv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_off_i |=> !conv_en_o);

    // R11
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_i || (ovr_o && !clr_flag_i)) |=> ovr_o);

endmodule

// File: rtl/acq_fifo_regs.sv
module acq_fifo_regs
    import acq_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    output logic              sw_conv_o,
    output logic              conv_en_o,
    output logic              dac_en_o,
    output logic              irq_o
);

    localparam int unsigned PAD_W = BUS_W - DATA_W;

    cmd_t              cmd;
    logic              take, ready, ovr;
    logic              empty, half, full, half_hit, drop;
    logic [DATA_W-1:0] head;
    logic [BUS_W-1:0]  status;

    acq_cmd_decode u_dec (
        .wr_en_i (bus_wr_i),
        .rd_en_i (bus_rd_i),
        .addr_i  (bus_addr_i),
        .cmd_o   (cmd)
    );

    acq_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_flag_i  (cmd.clr_flag),
        .dac_on_i    (cmd.dac_on),
        .poll_i      (cmd.poll),
        .conv_on_i   (cmd.conv_on),
        .conv_off_i  (cmd.conv_off),
        .smp_valid_i (smp_valid_i),
        .half_hit_i  (half_hit),
        .drop_i      (drop),
        .take_o      (take),
        .sw_conv_o   (sw_conv_o),
        .conv_en_o   (conv_en_o),
        .dac_en_o    (dac_en_o),
        .ready_o     (ready),
        .ovr_o       (ovr),
        .irq_o       (irq_o)
    );

    acq_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .pop_i      (cmd.pop_req),
        .clr_i      (cmd.clr_fifo),
        .wdata_i    (smp_data_i),
        .rdata_o    (head),
        .empty_o    (empty),
        .half_o     (half),
        .full_o     (full),
        .half_hit_o (half_hit),
        .drop_o     (drop)
    );

    always_comb begin
        status            = '0;
        status[ST_NEMPTY] = !empty;
        status[ST_NHALF]  = !half;
        status[ST_NFULL]  = !full;
        status[ST_READY]  = ready;
        status[ST_OVR]    = ovr;
        status[ST_CONV]   = conv_en_o;
        status[ST_NDAC]   = !dac_en_o;
        status[ST_IRQ]    = irq_o;
    end

    always_comb begin
        case (bus_addr_i)
            OFF_STATUS: bus_rdata_o = status;
            OFF_DATA:   bus_rdata_o = {{PAD_W{1'b0}}, head};
            default:    bus_rdata_o = '0;
        endcase
    end

    // R5
    sw_conv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_conv_o |=> !sw_conv_o);

    // R3
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half && !empty));

endmodule

// File: tb/acq_fifo_regs_tb.sv
module acq_fifo_regs_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  DEPTH = 1024;
    localparam int  HALF  = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_rdata;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        sw_conv, conv_en, dac_en, irq;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    int m_cnt = 0;
    bit m_rdy = 0, m_ovr = 0, m_cen = 0, m_dac = 0, m_irq = 0;
    logic [11:0] q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_fifo_regs u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_rdata_o (bus_rdata),
        .smp_valid_i (smp_valid),
        .smp_data_i  (smp_data),
        .sw_conv_o   (sw_conv),
        .conv_en_o   (conv_en),
        .dac_en_o    (dac_en),
        .irq_o       (irq)
    );

    always @(posedge clk) if (rst_n && sw_conv) pulses++;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        logic [15:0] s = '0;
        s[0]  = (m_cnt != 0);
        s[1]  = (m_cnt < HALF);
        s[2]  = (m_cnt != DEPTH);
        s[3]  = m_rdy;
        s[5]  = m_ovr;
        s[6]  = m_cen;
        s[7]  = !m_dac;
        s[14] = m_irq;
        return s;
    endfunction

    task automatic wr(logic [4:0] a);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(logic [11:0] v);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // push into model when accepted
    task automatic push_m(logic [11:0] v);
        push(v);
        if (m_cen) begin
            m_rdy = 1;
            if (m_cnt == DEPTH) m_ovr = 1;
            else begin
                q.push_back(v);
                m_cnt++;
                if (m_cnt == HALF) m_irq = 1;
            end
        end
    endtask

    task automatic stat(string req);
        logic [15:0] s;
        rd(5'h02, s);
        check(req, s, exp_status());
        check(req, {15'd0, irq}, {15'd0, m_irq});
    endtask

    task automatic pop_chk(string req);
        logic [15:0] d;
        rd(5'h06, d);
        check(req, d, {4'h0, q.pop_front()});
        m_cnt--;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        stat("R1");
        check("R1", {12'd0, sw_conv, conv_en, dac_en, irq}, 16'h0000);
        check("R1", exp_status(), 16'h0086);

        // R6 samples ignored while conversion blocked; R5 no pulse
        push_m(12'hABC);
        stat("R6");
        wr(5'h16);
        check("R5", 16'(pulses), 16'd0);

        wr(5'h18); m_cen = 1;
        stat("R6");
        check("R6", {15'd0, conv_en}, 16'd1);

        // R5 one pulse per poll write
        wr(5'h16);
        check("R5", 16'(pulses), 16'd1);

        // R4 ready on arrival, R2 right-justified read
        push_m(12'h123);
        stat("R4");
        pop_chk("R2");
        stat("R3");
        wr(5'h16); m_rdy = 0;
        check("R5", 16'(pulses), 16'd2);
        stat("R4");

        // R3 R10 fill sweep
        for (int i = 0; i < DEPTH; i++) begin
            push_m(12'((i * 37 + 5) % 4096));
            stat("R3/R10");
        end

        // R11 sample while full
        push_m(12'hFFF);
        stat("R11");

        // R8 clear flags; full stays, no new irq
        wr(5'h12); m_rdy = 0; m_ovr = 0; m_irq = 0;
        stat("R8");

        // R2 drain sweep in order
        for (int i = 0; i < DEPTH; i++) begin
            pop_chk("R2");
            stat("R3/R10");
        end

        // R12 read while empty
        begin
            logic [15:0] d;
            rd(5'h06, d);
        end
        stat("R12");
        push_m(12'h5A5);
        pop_chk("R12");

        // R10 refill to half, edge at exact count
        for (int i = 0; i < HALF; i++) begin
            push_m(12'(4095 - i));
            if (i >= HALF - 2) stat("R10");
        end

        // R7 clear FIFO, irq held
        wr(5'h10); m_cnt = 0; q.delete();
        stat("R7/R10");
        push_m(12'h777);
        pop_chk("R7");
        wr(5'h12); m_rdy = 0; m_ovr = 0; m_irq = 0;
        stat("R8");

        // R6 block conversion
        wr(5'h1A); m_cen = 0;
        push_m(12'h111);
        stat("R6");
        check("R6", {15'd0, conv_en}, 16'd0);

        // R9 analog outputs
        wr(5'h14); m_dac = 1;
        stat("R9");
        check("R9", {15'd0, dac_en}, 16'd1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule